// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 77 interrupt inputs and raises a single request line toward a processor. Each source has an enable, a 3-bit priority (0 lowest, 7 highest), a sensitivity (rising edge, falling edge, high level or low level) and a 32-bit vector. Software reaches a source's settings indirectly. It first writes the source number to a select register. The mode, vector, enable, disable and clear registers then act on that source.

Reading the interrupt-vector register returns the vector of the winning source and acknowledges it. The winner's priority goes onto an eight-entry nesting stack. A write to the end-of-interrupt register removes the top entry. While the stack holds a level, only a strictly higher priority can raise the request. When no source qualifies, a read returns a programmable spurious value. A key-guarded protect register can freeze the configuration registers.

The bus uses single-cycle strobes with word addresses:

| Address | Register |
|---|---|
| 0 | select |
| 1 | mode |
| 2 | vector |
| 3 | interrupt vector (read) |
| 4 | end-of-interrupt |
| 5 | spurious |
| 6 | enable command |
| 7 | disable command |
| 8 | clear command |
| 9 | protect |

Read data is combinational from the current state. Read side effects take place at the clock edge that ends the access.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every source is disabled, with priority 0, high-level type and vector 0. The select register is 0, the stack is empty, protection is off, the spurious value is 0 and `irq_o` is low.
- R2: A write to the select register takes a value below 77 and ignores any larger value. Reading address 0 returns the current selection.
- R3: The mode register holds the priority in bits [2:0] and the type in bits [5:4]. The type codes are 00 high level, 01 rising edge, 10 low level and 11 falling edge. A read returns the same layout for the selected source.
- R4: Sources 64 to 76 are external; all lower sources are internal. A mode write with type bit 5 set to an internal source is ignored as a whole.
- R5: A write with bit 0 set to the enable, disable or clear command enables the selected source, disables it, or drops its latched edge. A write with bit 0 clear has no effect.
- R6: An edge-type source latches its active edge even while disabled, and stays pending until acknowledged or cleared. A level-type source is pending exactly while its input is at the active level.
- R7: Among the enabled pending sources, the highest priority wins and the lowest index breaks ties. `irq_o` is high only if the stack is empty or the winner's priority is strictly above the top of the stack.
- R8: While `irq_o` is high, a read of address 3 returns the winner's vector, pushes its priority and clears its latched edge. An edge arriving on the same source in that same cycle stays latched.
- R9: While `irq_o` is low, a read of address 3 returns the spurious value and leaves the stack unchanged.
- R10: Any write to address 4 pops one stack level. A pop on an empty stack is ignored, so eight pops always empty the stack.
- R11: A write to address 9 whose bits [31:8] equal 0x5A17C0 sets protection to bit 0; any other value is ignored. While protection is on, writes to mode, vector and spurious are ignored. Address 9 reads back the protection bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| src_i | input | 77 | Interrupt source inputs |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
An acknowledge and a fresh edge can land on the same source in the same cycle. The acknowledge wants to drop the latched edge while the detector wants to set it. The bench provokes this directly: it primes a rising-edge source and then toggles its input in the very cycle the vector is read. After the end-of-interrupt, the request must rise again and the source must be delivered a second time. The random phase also mixes input toggles with vector reads and compares every result against a bench model that applies clears before sets.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int          NSRC      = 77,
  parameter int          NPRIO     = 8,
  parameter int          DW        = 32,
  parameter int          EXT_FIRST = 64,
  parameter logic [23:0] WP_KEY    = 24'h5A17C0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [3:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_i,
  output logic            irq_o
);

  localparam int SW = $clog2(NSRC);
  localparam int PW = $clog2(NPRIO);
  localparam int CW = $clog2(NPRIO + 1);

  localparam logic [3:0] A_SEL = 4'd0, A_MODE = 4'd1, A_VEC = 4'd2, A_IVR = 4'd3,
                         A_EOI = 4'd4, A_SPUR = 4'd5, A_EN = 4'd6, A_DIS = 4'd7,
                         A_CLR = 4'd8, A_WP = 4'd9;

  logic [SW-1:0]   sel;
  logic [NSRC-1:0] en, edg, prev, act, det, pend;
  logic [PW-1:0]   prio [NSRC];
  logic [1:0]      typ  [NSRC];
  logic [DW-1:0]   vec  [NSRC];
  logic [DW-1:0]   spur;
  logic            prot;
  logic [PW-1:0]   stk  [NPRIO];
  logic [CW-1:0]   cnt;

  logic            found;
  logic [PW-1:0]   best, top;
  logic [SW-1:0]   win;

  wire w_sel  = bus_wr && bus_addr == A_SEL;
  wire w_mode = bus_wr && bus_addr == A_MODE;
  wire w_vec  = bus_wr && bus_addr == A_VEC;
  wire w_eoi  = bus_wr && bus_addr == A_EOI;
  wire w_spur = bus_wr && bus_addr == A_SPUR;
  wire w_en   = bus_wr && bus_addr == A_EN  && bus_wdata[0];
  wire w_dis  = bus_wr && bus_addr == A_DIS && bus_wdata[0];
  wire w_clr  = bus_wr && bus_addr == A_CLR && bus_wdata[0];
  wire w_wp   = bus_wr && bus_addr == A_WP  && bus_wdata[DW-1:DW-24] == WP_KEY;

  wire sel_ext = int'(sel) >= EXT_FIRST;
  wire mode_ok = w_mode && !prot && (sel_ext || !bus_wdata[5]);

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      act[i]  = src_i[i] ^ typ[i][1];
      det[i]  = typ[i][0] & act[i] & ~(prev[i] ^ typ[i][1]);
      pend[i] = en[i] & (typ[i][0] ? edg[i] : act[i]);
    end
  end

  always_comb begin
    found = 1'b0;
    best  = '0;
    win   = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && (!found || prio[i] > best)) begin
        found = 1'b1;
        best  = prio[i];
        win   = SW'(i);
      end
  end

  assign top   = stk[PW'(cnt - 1'b1)];
  assign irq_o = found && (cnt == '0 || best > top);

  wire ack  = bus_rd && bus_addr == A_IVR && irq_o;
  wire push = ack && cnt != CW'(NPRIO);
  wire pop  = w_eoi && cnt != '0;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SEL:   bus_rdata[SW-1:0] = sel;
      A_MODE:  begin bus_rdata[PW-1:0] = prio[sel]; bus_rdata[5:4] = typ[sel]; end
      A_VEC:   bus_rdata = vec[sel];
      A_IVR:   bus_rdata = irq_o ? vec[win] : spur;
      A_SPUR:  bus_rdata = spur;
      A_WP:    bus_rdata[0] = prot;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel  <= '0;
      en   <= '0;
      edg  <= '0;
      prev <= '0;
      spur <= '0;
      prot <= 1'b0;
      cnt  <= '0;
      for (int i = 0; i < NSRC; i++) begin
        prio[i] <= '0;
        typ[i]  <= 2'b00;
        vec[i]  <= '0;
      end
      for (int j = 0; j < NPRIO; j++) stk[j] <= '0;
    end else begin
      prev <= src_i;
      if (w_sel && bus_wdata < DW'(NSRC)) sel <= bus_wdata[SW-1:0];
      if (mode_ok) begin
        prio[sel] <= bus_wdata[PW-1:0];
        typ[sel]  <= bus_wdata[5:4];
      end
      if (w_vec && !prot)  vec[sel] <= bus_wdata;
      if (w_spur && !prot) spur <= bus_wdata;
      if (w_en)  en[sel] <= 1'b1;
      if (w_dis) en[sel] <= 1'b0;
      for (int i = 0; i < NSRC; i++)
        edg[i] <= (edg[i] & ~((w_clr && sel == SW'(i)) || (ack && win == SW'(i)))) | det[i];
      if (w_wp) prot <= bus_wdata[0];
      if (push && pop) stk[PW'(cnt - 1'b1)] <= best;
      else if (push) begin
        stk[PW'(cnt)] <= best;
        cnt <= cnt + 1'b1;
      end else if (pop) cnt <= cnt - 1'b1;
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(NPRIO)); // R10
  AST_STACK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    cnt >= CW'(2) |-> stk[PW'(cnt - 1'b1)] > stk[PW'(cnt - CW'(2))]); // R7
  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !w_eoi) |=> cnt == $past(cnt) + CW'(1)); // R8
  AST_SPUR_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_IVR && !irq_o && !w_eoi) |=> $stable(cnt)); // R9
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (w_eoi && cnt == '0 && !ack) |=> cnt == '0); // R10
  AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (prot && w_spur) |=> $stable(spur)); // R11

  for (genvar g = 0; g < NSRC && g < EXT_FIRST; g++) begin : g_int
    AST_INT_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
      !typ[g][1]); // R4
  end

endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam int NS = 77;
  localparam int EXT = 64;
  localparam logic [23:0] KEY = 24'h5A17C0;
  localparam logic [3:0] A_SEL = 0, A_MODE = 1, A_VEC = 2, A_IVR = 3, A_EOI = 4,
                         A_SPUR = 5, A_EN = 6, A_DIS = 7, A_CLR = 8, A_WP = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NS-1:0] src = '0;
  logic          irq;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .src_i(src), .irq_o(irq));

  bit          m_en [NS], m_edg [NS], m_prev [NS];
  logic [2:0]  m_prio [NS];
  logic [1:0]  m_typ [NS];
  logic [31:0] m_vec [NS];
  logic [31:0] m_spur = '0;
  int          m_stk [8];
  int          m_cnt = 0, m_sel = 0, clr_idx = -1;
  bit          m_prot = 0;
  int          nchk = 0, nerr = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int mwin();
    int b = -1;
    int bp = 0;
    for (int i = 0; i < NS; i++) begin
      bit p = m_en[i] && (m_typ[i][0] ? m_edg[i] : (src[i] ^ m_typ[i][1]));
      if (p && (b < 0 || int'(m_prio[i]) > bp)) begin
        b = i;
        bp = int'(m_prio[i]);
      end
    end
    if (b >= 0 && m_cnt > 0 && bp <= m_stk[m_cnt-1]) b = -1;
    return b;
  endfunction

  task automatic tick();
    @(posedge clk);
    for (int i = 0; i < NS; i++) begin
      bit a  = src[i] ^ m_typ[i][1];
      bit pa = m_prev[i] ^ m_typ[i][1];
      if (clr_idx == i) m_edg[i] = 0;
      if (m_typ[i][0] && a && !pa) m_edg[i] = 1;
      m_prev[i] = src[i];
    end
    clr_idx = -1;
    #1;
    wr = 1'b0;
    rd = 1'b0;
  endtask

  task automatic w(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    if (a == A_CLR && d[0]) clr_idx = m_sel;
    tick();
    case (a)
      A_SEL:  if (d < NS) m_sel = int'(d);
      A_MODE: if (!m_prot && (m_sel >= EXT || !d[5])) begin
                m_typ[m_sel] = d[5:4]; m_prio[m_sel] = d[2:0];
              end
      A_VEC:  if (!m_prot) m_vec[m_sel] = d;
      A_SPUR: if (!m_prot) m_spur = d;
      A_EN:   if (d[0]) m_en[m_sel] = 1;
      A_DIS:  if (d[0]) m_en[m_sel] = 0;
      A_EOI:  if (m_cnt > 0) m_cnt--;
      A_WP:   if (d[31:8] == KEY) m_prot = d[0];
      default: ;
    endcase
  endtask

  task automatic rr(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 v = rdata;
    tick();
  endtask

  task automatic ivr(input string req, input int tog = -1);
    int wn;
    @(negedge clk);
    rd = 1'b1; addr = A_IVR;
    if (tog >= 0) src[tog] = ~src[tog];
    #1;
    wn = mwin();
    chk({req, " irq"}, 32'(irq), 32'(wn >= 0));
    chk({req, " vector"}, rdata, wn >= 0 ? m_vec[wn] : m_spur);
    if (wn >= 0) clr_idx = wn;
    tick();
    if (wn >= 0 && m_cnt < 8) begin m_stk[m_cnt] = int'(m_prio[wn]); m_cnt++; end
  endtask

  task automatic setsrc(input int i, input logic v);
    @(negedge clk);
    src[i] = v;
    tick();
  endtask

  task automatic irqchk(input string req);
    @(negedge clk);
    #1 chk(req, 32'(irq), 32'(mwin() >= 0));
  endtask

  task automatic cfg(input int s, input logic [1:0] t, input logic [2:0] p, input bit e);
    w(A_SEL, s);
    w(A_MODE, {26'd0, t, 1'b0, p});
    w(e ? A_EN : A_DIS, 1);
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < NS; i++) begin
      m_en[i] = 0; m_edg[i] = 0; m_prev[i] = 0; m_prio[i] = 0; m_typ[i] = 0; m_vec[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    irqchk("R1");
    chk("R1 irq low", 32'(irq), 0);
    rr(A_MODE, v); chk("R1 mode", v, 0);
    rr(A_SEL, v);  chk("R1 select", v, 0);
    rr(A_WP, v);   chk("R1 protect", v, 0);
    ivr("R1");

    for (int i = 0; i < NS; i++) begin
      w(A_SEL, i);
      w(A_VEC, 32'h100 + i);
    end
    w(A_SPUR, 32'hDEAD);

    w(A_SEL, 77);  rr(A_SEL, v); chk("R2 select 77 ignored", v, 76);
    w(A_SEL, 127); rr(A_SEL, v); chk("R2 select 127 ignored", v, 76);
    w(A_SEL, 12);  rr(A_SEL, v); chk("R2 select legal", v, 12);

    w(A_SEL, 5); w(A_MODE, 32'h23);
    rr(A_MODE, v); chk("R4 internal low-level ignored", v, 0);
    w(A_MODE, 32'h15);
    rr(A_MODE, v); chk("R3 mode layout", v, 32'h15);
    w(A_SEL, 70); w(A_MODE, 32'h32);
    rr(A_MODE, v); chk("R4 external falling accepted", v, 32'h32);
    cfg(5, 2'b00, 0, 0);

    cfg(3, 2'b01, 4, 0);
    w(A_EN, 0);
    setsrc(3, 1);
    irqchk("R5"); chk("R5 enable bit0 clear ignored", 32'(irq), 0);
    w(A_EN, 1);
    irqchk("R6"); chk("R6 edge latched while disabled", 32'(irq), 1);
    w(A_CLR, 0);
    irqchk("R5"); chk("R5 clear bit0 clear ignored", 32'(irq), 1);
    w(A_CLR, 1);
    irqchk("R5"); chk("R5 clear drops edge", 32'(irq), 0);
    setsrc(3, 0); setsrc(3, 1);
    ivr("R8");
    irqchk("R8"); chk("R8 edge cleared by ack", 32'(irq), 0);
    w(A_EOI, 0);
    w(A_DIS, 0);
    irqchk("R5"); chk("R5 disable bit0 clear ignored", 32'(irq), 0);
    w(A_DIS, 1);
    setsrc(3, 0);

    cfg(20, 2'b00, 5, 1); cfg(10, 2'b00, 5, 1);
    setsrc(20, 1); setsrc(10, 1);
    irqchk("R6");
    ivr("R7 tie lowest index");
    chk("R7 tie stack", 32'(m_stk[0]), 5);
    irqchk("R7"); chk("R7 equal priority masked", 32'(irq), 0);
    cfg(30, 2'b00, 6, 1); setsrc(30, 1);
    irqchk("R7"); chk("R7 higher priority passes", 32'(irq), 1);
    ivr("R7 nested");
    w(A_EOI, 0); w(A_EOI, 0);
    ivr("R6 level stays pending");
    w(A_EOI, 0);
    setsrc(10, 0); setsrc(20, 0); setsrc(30, 0);
    irqchk("R6"); chk("R6 level drops with input", 32'(irq), 0);
    for (int s = 10; s <= 30; s += 10) cfg(s, 2'b00, 0, 0);

    for (int k = 0; k < 8; k++) w(A_EOI, 0);
    ivr("R10 empty pops ignored");

    for (int k = 0; k < 8; k++) begin
      cfg(40 + k, 2'b00, 3'(k), 1);
      setsrc(40 + k, 1);
      ivr("R8 fill");
    end
    chk("R10 stack full", 32'(m_cnt), 8);
    ivr("R9 full stack spurious");
    for (int k = 0; k < 8; k++) w(A_EOI, 0);
    ivr("R10 eight pops empty");
    w(A_EOI, 0);
    for (int k = 0; k < 8; k++) begin
      setsrc(40 + k, 0);
      cfg(40 + k, 2'b00, 0, 0);
    end

    cfg(65, 2'b01, 3, 1);
    setsrc(65, 1); setsrc(65, 0);
    ivr("R8 ack with same-cycle edge", 65);
    irqchk("R8"); chk("R8 masked by own level", 32'(irq), 0);
    w(A_EOI, 0);
    irqchk("R8"); chk("R8 new edge survived ack", 32'(irq), 1);
    ivr("R8 second delivery");
    w(A_EOI, 0);
    irqchk("R8"); chk("R8 drained", 32'(irq), 0);
    cfg(65, 2'b00, 0, 0); setsrc(65, 0);

    cfg(70, 2'b10, 2, 1);
    irqchk("R6"); chk("R6 low level pending", 32'(irq), 1);
    ivr("R6 low level");
    w(A_EOI, 0);
    setsrc(70, 1);
    irqchk("R6"); chk("R6 low level idle", 32'(irq), 0);
    cfg(70, 2'b00, 0, 0); setsrc(70, 0);

    w(A_WP, {KEY, 8'h01});
    rr(A_WP, v); chk("R11 protect on", v, 1);
    w(A_SPUR, 32'hBEEF);
    ivr("R11 spurious frozen");
    w(A_SEL, 9); w(A_MODE, 32'h17);
    rr(A_MODE, v); chk("R11 mode frozen", v, 0);
    w(A_WP, {~KEY, 8'h00});
    rr(A_WP, v); chk("R11 wrong key ignored", v, 1);
    w(A_WP, {KEY, 8'h00});
    rr(A_WP, v); chk("R11 protect off", v, 0);
    w(A_SPUR, 32'hBEEF);
    ivr("R11 spurious writable");

    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom % 8);
      int s  = int'($urandom % NS);
      case (op)
        0: begin
          w(A_SEL, s);
          w(A_MODE, {26'd0, 2'($urandom), 1'b0, 3'($urandom)});
          rr(A_MODE, v);
          chk("R3 R4 random mode", v, {26'd0, m_typ[m_sel], 1'b0, m_prio[m_sel]});
        end
        1: begin w(A_SEL, s); w(($urandom % 2) ? A_EN : A_DIS, 1); end
        2, 3: setsrc(s, ~src[s]);
        4: ivr("R7 R8 random");
        5: ivr("R8 random toggle", s);
        6: w(A_EOI, $urandom);
        default: begin w(A_SEL, s); w(A_CLR, 1); irqchk("R5 random clear"); end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule